// File: doc/BRIEF.md
# Doorbell-Signalled Request Ring

This block is a single-producer, single-consumer ring of fixed-width request entries kept in on-chip memory. A producer presents an entry with a valid strobe. When a slot is free, the block stores the entry at the write pointer, advances the pointer and marks the slot occupied. Every accepted entry also sets a doorbell status bit, which becomes an interrupt when its enable bit is set.

A drain engine on the consumer side sits idle until the interrupt is raised and the ring holds at least one entry. From then on it presents entries in order, one at a time. Each presented entry stays on the consumer port until the consumer pulses a done strobe. That strobe clears the slot's occupied (recycle) flag and advances the read pointer. The engine keeps fetching without regard to the doorbell until the ring is empty, and only then returns to idle. A doorbell raised while it works simply stays pending.

A small register port lets either side read both pointers, the status bits and the occupied flags at any time. Through the same port software sets status bits by writing ones, clears them through a separate acknowledge register, and programs the enable mask. A push into a full ring is refused and sets a sticky overflow status bit.

Top module: `req_ring_top`

## Requirements
- R1: An accepted push writes its data into the slot at the write pointer and advances the write pointer by exactly one. Entries reach the consumer port in the order they were accepted. Pointers are DEPTH-wrapping counts with one extra wrap bit.
- R2: `prod_ready` is low exactly when DEPTH entries are held. Status register bit 3 reads full and bit 2 reads empty.
- R3: A push while full is refused and leaves the write pointer unchanged. It sets overflow status bit 1, which stays set until acknowledged.
- R4: Each accepted push sets doorbell status bit 0. Writing 1 to bit n of the set register (address 3) sets status bit n, and writing 0 there changes nothing.
- R5: Writing 1 to bit n of the acknowledge register (address 4) clears status bit n. When a set and an acknowledge reach the same bit in the same cycle, the bit ends up set.
- R6: `irq` equals the OR over n of (status bit n AND enable bit n). It is registered and changes in the same cycle as the status or enable bits.
- R7: The drain engine leaves idle only when the ring is non-empty and `irq` is high. Once started, it keeps presenting entries until the ring is empty, regardless of `irq`. `cons_valid` is high only while an entry is presented.
- R8: `cons_done` while an entry is presented clears that slot's occupied flag and advances the read pointer by one. At any other time `cons_done` is ignored.
- R9: Register reads return data one cycle after the address: 0 gives the write pointer, 1 the read pointer, 2 the status {full, empty, overflow, doorbell} in bits 3..0, 5 the enable mask and 6 the occupied flags, one bit per slot. An accepted push sets its slot's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_valid | input | 1 | Producer offers an entry this cycle |
| prod_data | input | DATA_W | Entry contents |
| prod_ready | output | 1 | Ring has a free slot |
| cons_valid | output | 1 | An entry is presented to the consumer |
| cons_data | output | DATA_W | Presented entry contents |
| cons_done | input | 1 | Consumer has finished the presented entry |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Register write data (one bit per status source) |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Doorbell interrupt toward the consumer |

## Verification
Several properties are checked on every cycle by the assertions. The write pointer moves by exactly one per accepted push. The distance between the pointers never exceeds the depth. A refused push leaves the write pointer alone and raises overflow. Every accepted push leaves the doorbell bit set. The read pointer stands still unless a presented entry is completed. The interrupt always matches the enabled status bits. Other behaviours need the bench's scenarios to show them: entry ordering, the engine refusing to start while the interrupt is masked, draining on after a mid-run acknowledge, a set winning over a simultaneous acknowledge, and the register read map.

// File: rtl/req_ring_pkg.sv
`timescale 1ns/1ps
package req_ring_pkg;
  localparam int REG_AW = 3;
  localparam int REG_W  = 32;
  localparam int NSRC   = 2;   // status sources: 0 doorbell, 1 overflow

  localparam logic [REG_AW-1:0] RA_WPTR = 3'd0;
  localparam logic [REG_AW-1:0] RA_RPTR = 3'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd2;
  localparam logic [REG_AW-1:0] RA_SET  = 3'd3;
  localparam logic [REG_AW-1:0] RA_ACK  = 3'd4;
  localparam logic [REG_AW-1:0] RA_EN   = 3'd5;
  localparam logic [REG_AW-1:0] RA_FLAG = 3'd6;

  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_FETCH = 2'd1,
    DR_SHOW  = 2'd2
  } drain_st_e;
endpackage

// File: rtl/ring_ptrs.sv
`timescale 1ns/1ps
module ring_ptrs #(
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic [PW-1:0]    wptr,
  output logic [PW-1:0]    rptr,
  output logic             full,
  output logic             empty,
  output logic             one_left,
  output logic             push_ok,
  output logic             push_rej,
  output logic [DEPTH-1:0] busy
);
  logic [PW-1:0] fill;
  logic          pop_ok;

  assign fill     = wptr - rptr;
  assign full     = (fill == PW'(DEPTH));
  assign empty    = (fill == '0);
  assign one_left = (fill == PW'(1));
  assign push_ok  = push_req & ~full;
  assign push_rej = push_req & full;
  assign pop_ok   = pop_req & ~empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      busy <= '0;
    end else begin
      if (push_ok) begin
        wptr                <= wptr + PW'(1);
        busy[wptr[AW-1:0]]  <= 1'b1;
      end
      if (pop_ok) begin
        rptr                <= rptr + PW'(1);
        busy[rptr[AW-1:0]]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ring_store.sv
`timescale 1ns/1ps
module ring_store #(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ring_doorbell.sv
`timescale 1ns/1ps
module ring_doorbell #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] hw_set,
  input  logic [NSRC-1:0] sw_set,
  input  logic [NSRC-1:0] sw_clr,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  output logic [NSRC-1:0] sts,
  output logic [NSRC-1:0] en,
  output logic            irq
);
  logic [NSRC-1:0] sts_d;
  logic [NSRC-1:0] en_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // a set in the same cycle as a clear wins
    assign sts_d[i] = hw_set[i] | sw_set[i] | (sts[i] & ~sw_clr[i]);
    assign en_d[i]  = en_we ? en_wdata[i] : en[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      sts <= sts_d;
      en  <= en_d;
      irq <= |(sts_d & en_d);
    end
  end
endmodule

// File: rtl/ring_drain.sv
`timescale 1ns/1ps
module ring_drain
  import req_ring_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic empty,
  input  logic one_left,
  input  logic done,
  output logic fetch,
  output logic release_ent,
  output logic show
);
  drain_st_e st, st_n;

  assign fetch       = (st == DR_FETCH);
  assign show        = (st == DR_SHOW);
  assign release_ent = (st == DR_SHOW) & done;

  always_comb begin
    st_n = st;
    case (st)
      DR_IDLE:  if (!empty && irq) st_n = DR_FETCH;
      DR_FETCH: st_n = DR_SHOW;
      DR_SHOW:  if (done) st_n = one_left ? DR_IDLE : DR_FETCH;
      default:  st_n = DR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= DR_IDLE;
    else     st <= st_n;
  end
endmodule

// File: rtl/req_ring_top.sv
`timescale 1ns/1ps
module req_ring_top
  import req_ring_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prod_valid,
  input  logic [DATA_W-1:0] prod_data,
  output logic              prod_ready,
  output logic              cons_valid,
  output logic [DATA_W-1:0] cons_data,
  input  logic              cons_done,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [PW-1:0]    wptr, rptr;
  logic             full, empty, one_left, push_ok, push_rej;
  logic [DEPTH-1:0] busy;
  logic [NSRC-1:0]  sts, en, hw_set, sw_set, sw_clr;
  logic             fetch, release_ent, show, en_we;

  ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push_req(prod_valid), .pop_req(release_ent),
    .wptr(wptr), .rptr(rptr), .full(full), .empty(empty), .one_left(one_left),
    .push_ok(push_ok), .push_rej(push_rej), .busy(busy)
  );

  ring_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(push_ok), .waddr(wptr[AW-1:0]), .wdata(prod_data),
    .re(fetch), .raddr(rptr[AW-1:0]), .rdata(cons_data)
  );

  assign hw_set = {push_rej, push_ok};
  assign sw_set = (reg_wr && reg_addr == RA_SET) ? reg_wdata : '0;
  assign sw_clr = (reg_wr && reg_addr == RA_ACK) ? reg_wdata : '0;
  assign en_we  = reg_wr && (reg_addr == RA_EN);

  ring_doorbell #(.NSRC(NSRC)) u_bell (
    .clk(clk), .rst(rst), .hw_set(hw_set), .sw_set(sw_set), .sw_clr(sw_clr),
    .en_we(en_we), .en_wdata(reg_wdata), .sts(sts), .en(en), .irq(irq)
  );

  ring_drain u_drain (
    .clk(clk), .rst(rst), .irq(irq), .empty(empty), .one_left(one_left),
    .done(cons_done), .fetch(fetch), .release_ent(release_ent), .show(show)
  );

  assign prod_ready = ~full;
  assign cons_valid = show;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_WPTR: reg_rdata <= REG_W'(wptr);
        RA_RPTR: reg_rdata <= REG_W'(rptr);
        RA_STAT: reg_rdata <= REG_W'({full, empty, sts});
        RA_EN:   reg_rdata <= REG_W'(en);
        RA_FLAG: reg_rdata <= REG_W'(busy);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/req_ring_chk.sv
`timescale 1ns/1ps
module req_ring_chk #(
  parameter  int DEPTH = 8,
  parameter  int NSRC  = 2,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            prod_valid,
  input logic            prod_ready,
  input logic            cons_valid,
  input logic            cons_done,
  input logic            irq,
  input logic [PW-1:0]   wptr,
  input logic [PW-1:0]   rptr,
  input logic [NSRC-1:0] sts,
  input logic [NSRC-1:0] en
);
  logic [PW-1:0] fill;
  assign fill = wptr - rptr;

  assert_wptr_step_R1: assert property (@(posedge clk) disable iff (rst)
    (prod_valid && prod_ready) |=> (wptr == $past(wptr) + PW'(1)));

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
    fill <= PW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (prod_valid && !prod_ready) |=> (sts[1] && $stable(wptr)));

  assert_push_rings_R4: assert property (@(posedge clk) disable iff (rst)
    (prod_valid && prod_ready) |=> sts[0]);

  assert_irq_mask_R6: assert property (@(posedge clk) disable iff (rst)
    irq == |(sts & en));

  assert_show_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    cons_valid |-> (fill != '0));

  assert_rptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(cons_valid && cons_done) |=> $stable(rptr));
endmodule

bind req_ring_top req_ring_chk #(.DEPTH(DEPTH), .NSRC(req_ring_pkg::NSRC)) u_chk (
  .clk(clk), .rst(rst), .prod_valid(prod_valid), .prod_ready(prod_ready),
  .cons_valid(cons_valid), .cons_done(cons_done), .irq(irq),
  .wptr(wptr), .rptr(rptr), .sts(sts), .en(en)
);

// File: tb/req_ring_top_tb.sv
`timescale 1ns/1ps
module req_ring_top_tb;
  localparam int DEPTH = 8;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          prod_valid;
  logic [DW-1:0] prod_data;
  logic          prod_ready;
  logic          cons_valid;
  logic [DW-1:0] cons_data;
  logic          cons_done;
  logic [2:0]    reg_addr;
  logic          reg_wr;
  logic [1:0]    reg_wdata;
  logic [31:0]   reg_rdata;
  logic          irq;

  always #2.5 clk = ~clk;

  req_ring_top #(.DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .prod_valid(prod_valid), .prod_data(prod_data),
    .prod_ready(prod_ready), .cons_valid(cons_valid), .cons_data(cons_data),
    .cons_done(cons_done), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int total = 0;
  int bad   = 0;
  bit started  = 0;
  bit finished = 0;
  bit auto_ack = 0;
  bit force_done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [DW-1:0]    mq[$];
  int               mw, mr, mst, cnt;
  bit [DEPTH-1:0]   mflag;
  bit [1:0]         msts, men, mset, mclr;
  bit               mirq, irq_now, acc, rej;
  logic [DW-1:0]    mcd;
  logic [31:0]      mrd;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mw = 0; mr = 0; mst = 0; mflag = '0;
      msts = '0; men = '0; mirq = 0; mrd = '0; mcd = '0;
    end else begin
      cnt     = mq.size();
      irq_now = |(msts & men);
      case (reg_addr)
        3'd0: mrd = 32'(mw);
        3'd1: mrd = 32'(mr);
        3'd2: mrd = {28'd0, cnt == DEPTH, cnt == 0, msts};
        3'd5: mrd = {30'd0, men};
        3'd6: mrd = 32'(mflag);
        default: mrd = '0;
      endcase
      acc  = prod_valid && (cnt < DEPTH);
      rej  = prod_valid && (cnt == DEPTH);
      mset = {rej, acc};
      mclr = '0;
      if (reg_wr && reg_addr == 3'd3) mset = mset | reg_wdata;
      if (reg_wr && reg_addr == 3'd4) mclr = reg_wdata;
      msts = (msts & ~mclr) | mset;
      if (reg_wr && reg_addr == 3'd5) men = reg_wdata;
      case (mst)
        0: if (cnt > 0 && irq_now) mst = 1;
        1: begin mcd = mq[0]; mst = 2; end
        default: if (cons_done) begin
          mflag[mr % DEPTH] = 1'b0;
          mr = (mr + 1) % (2 * DEPTH);
          void'(mq.pop_front());
          mst = (cnt == 1) ? 0 : 1;
        end
      endcase
      if (acc) begin
        mflag[mw % DEPTH] = 1'b1;
        mq.push_back(prod_data);
        mw = (mw + 1) % (2 * DEPTH);
      end
      mirq = |(msts & men);
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(prod_ready == (mq.size() < DEPTH), "R2 prod_ready", 32'(prod_ready), 32'(mq.size() < DEPTH));
      chk(irq == mirq, "R6 irq", 32'(irq), 32'(mirq));
      chk(cons_valid == (mst == 2), "R7 cons_valid", 32'(cons_valid), 32'(mst == 2));
      if (mst == 2) chk(cons_data == mcd, "R1 cons_data order", cons_data, mcd);
      chk(reg_rdata == mrd, "R9 reg_rdata", reg_rdata, mrd);
    end
  end

  // consumer responder
  initial begin
    cons_done = 1'b0;
    forever begin
      @(negedge clk);
      cons_done = (auto_ack && cons_valid) || force_done;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic push(input logic [DW-1:0] d);
    @(negedge clk); prod_valid = 1'b1; prod_data = d;
    @(negedge clk); prod_valid = 1'b0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [1:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a;
    @(negedge clk); chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; prod_valid = 1'b0; prod_data = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0; started = 1;

    // reset state
    chk(irq == 1'b0, "R6 reset irq", 32'(irq), 0);
    chk(cons_valid == 1'b0, "R7 reset cons_valid", 32'(cons_valid), 0);
    rreg(3'd0, 32'd0, "R9 reset wptr");
    rreg(3'd2, 32'h4, "R2 reset status empty");

    // masked doorbell: entries wait, engine stays idle
    push(32'hA0A0_0001); push(32'hB0B0_0002); push(32'hC0C0_0003);
    rreg(3'd2, 32'h1, "R4 doorbell set by push");
    rreg(3'd6, 32'h07, "R9 occupied flags");
    chk(cons_valid == 1'b0, "R7 no start while masked", 32'(cons_valid), 0);
    @(negedge clk); force_done = 1'b1; @(negedge clk); force_done = 1'b0;
    rreg(3'd1, 32'd0, "R8 done while idle ignored");

    // unmask and drain
    auto_ack = 1;
    wreg(3'd5, 2'b01);
    idle(20);
    rreg(3'd1, 32'd3, "R8 rptr after drain");
    rreg(3'd6, 32'h00, "R8 flags released");
    rreg(3'd2, 32'h5, "R7 idle with pending doorbell");
    wreg(3'd4, 2'b01);
    rreg(3'd2, 32'h4, "R5 ack clears doorbell");
    chk(irq == 1'b0, "R6 irq low after ack", 32'(irq), 0);

    // ack mid-drain: engine continues without doorbell
    auto_ack = 0;
    push(32'hD0D0_0004); push(32'hE0E0_0005);
    while (!cons_valid) @(negedge clk);
    wreg(3'd4, 2'b01);
    chk(irq == 1'b0, "R7 irq acked mid-drain", 32'(irq), 0);
    auto_ack = 1;
    idle(20);
    rreg(3'd1, 32'd5, "R7 drained after ack");

    // fill and overflow
    auto_ack = 0;
    wreg(3'd5, 2'b00);
    for (int i = 0; i < DEPTH; i++) push(32'h1000_0000 + 32'(i));
    chk(prod_ready == 1'b0, "R2 full blocks producer", 32'(prod_ready), 0);
    rreg(3'd2, 32'h9, "R2 full status");
    push(32'hDEAD_BEEF);
    rreg(3'd2, 32'hB, "R3 overflow raised");
    rreg(3'd0, 32'd13, "R3 wptr held on reject");
    wreg(3'd4, 2'b01);
    rreg(3'd2, 32'hA, "R3 overflow sticky");
    wreg(3'd3, 2'b00);
    rreg(3'd2, 32'hA, "R4 set with zero no effect");
    wreg(3'd3, 2'b01);
    rreg(3'd2, 32'hB, "R4 software set");

    // overflow interrupt drives drain
    auto_ack = 1;
    wreg(3'd5, 2'b10);
    chk(irq == 1'b1, "R6 overflow enabled", 32'(irq), 1);
    idle(40);
    rreg(3'd1, 32'd13, "R1 all entries consumed");
    rreg(3'd2, 32'h7, "R2 empty after drain");
    wreg(3'd4, 2'b11);
    rreg(3'd2, 32'h4, "R5 ack both");

    // simultaneous push and ack: set wins
    @(negedge clk);
    prod_valid = 1'b1; prod_data = 32'h5555_AAAA;
    reg_addr = 3'd4; reg_wdata = 2'b01; reg_wr = 1'b1;
    @(negedge clk);
    prod_valid = 1'b0; reg_wr = 1'b0;
    rreg(3'd2, 32'h1, "R5 set beats ack");
    rreg(3'd6, 32'h20, "R9 flag at wrapped slot");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule